// File: doc/BRIEF.md
# Greedy Marginal-Gain Cache Partitioner

This block works out how many cache blocks each running process should own for the next time slice. Every process has a curve of marginal gains: the extra hits it would earn from one more block. The partitioner starts every process at zero blocks. It then hands blocks out one at a time. Each block goes to the process whose next block is worth the most. The run is repeated after every time slice, once the gain counters have been refreshed.

A start pulse captures three values: the number of active processes, the number of blocks to hand out, and a per-process cap. After that the block performs one allocation step per clock cycle. The gains come from an external table with one asynchronous read lane per process. The address on lane i is the current allocation of process i. The data returned on that lane is that process's gain for its next block. Processes that have reached the cap drop out of the contest. The run ends early if every process is capped. When the run finishes, a one-cycle done pulse is raised and the counts are held until the next start.

Top module: `mgain_partitioner`

## Requirements
- R1: During and right after reset, `busy` and `done` are 0 and every allocation count is 0.
- R2: A start pulse accepted while idle sets `busy` and clears every allocation count to 0. Both are visible in the cycle after the start edge.
- R3: Each step adds exactly one block to the eligible process with the largest gain. Process i presents its current count on `gain_addr[i*CNT_W +: CNT_W]`. It reads its next-block gain back on `gain_data[i*GAIN_W +: GAIN_W]`, compared as an unsigned value.
- R4: When eligible processes have equal largest gains, the one with the lowest index gets the block.
- R5: A run makes one step per cycle and no more steps than `total_blocks`. `done` is high in the cycle after the (steps+1)-th rising edge following the start edge, so `busy` is high for steps+1 cycles. A total of 0 finishes after one busy cycle.
- R6: No allocation count ever exceeds `cap_blocks` as captured at start. A process whose count equals the cap is not eligible.
- R7: If no active process is eligible, the run stops early with the blocks that are left ungiven. The timing of R5 still holds for the steps actually made.
- R8: Only processes 0 to `nproc_active`-1 take part. The count of every other process stays 0. With `nproc_active` = 0 the run ends at once with all counts 0.
- R9: `done` lasts exactly one cycle. While idle and with no start, the allocation counts do not change.
- R10: A start pulse that arrives while `busy` is high is ignored. The running job finishes with its original parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new partition run when idle |
| nproc_active | input | $clog2(NPROC+1) | Number of processes taking part |
| total_blocks | input | CNT_W | Blocks to hand out |
| cap_blocks | input | CNT_W | Per-process block limit |
| gain_addr | output | NPROC*CNT_W | Per-process gain table read address (current count) |
| gain_data | input | NPROC*GAIN_W | Per-process next-block gain, asynchronous read |
| alloc_counts | output | NPROC*CNT_W | Per-process allocation counts |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The bench builds the block with NPROC=4, CNT_W=5 and GAIN_W=8. With four processes the selection tree is two levels deep, so every tie position and every inactive-process boundary can be exercised. Because counts are only five bits wide, caps of 4 to 8 are reached within a few dozen steps. That makes the early-stop case with all processes capped short to run. The gain table offers three shapes: falling curves, flat equal gains that force ties, and a non-monotonic pattern. Together they exercise the winner choice both when the greedy order is simple and when it jumps between processes.

// File: rtl/mgp_pkg.sv
package mgp_pkg;

  typedef enum logic {ST_IDLE, ST_RUN} run_state_e;

  // Left subtree holds lower indices, so it keeps the win on equal gains.
  function automatic logic left_wins(input logic lv, input logic rv,
                                     input logic [31:0] lg, input logic [31:0] rg);
    return lv && (!rv || (lg >= rg));
  endfunction

  // A process may compete when it is active and still under the cap.
  function automatic logic may_compete(input logic [31:0] idx, input logic [31:0] nact,
                                       input logic [31:0] cnt, input logic [31:0] cap);
    return (idx < nact) && (cnt < cap);
  endfunction

endpackage

// File: rtl/mgp_argmax.sv
module mgp_argmax import mgp_pkg::*; #(
  parameter int NPROC  = 8,
  parameter int GAIN_W = 16,
  parameter int IDX_W  = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPROC-1:0]        elig,
  input  logic [NPROC*GAIN_W-1:0] gains,
  output logic                    win_valid,
  output logic [IDX_W-1:0]        win_idx
);
  localparam int LVL   = (NPROC > 1) ? $clog2(NPROC) : 1;
  localparam int NLEAF = 1 << LVL;
  localparam int NODES = 2 * NLEAF - 1;

  // Heap-ordered tree: node 0 is the root, children of n are 2n+1 and 2n+2.
  logic [NODES-1:0]        nv;
  logic [NODES*GAIN_W-1:0] ng;
  logic [NODES*IDX_W-1:0]  ni;
  logic [GAIN_W-1:0]       win_gain;

  for (genvar i = 0; i < NLEAF; i++) begin : g_leaf
    localparam int N = NLEAF - 1 + i;
    if (i < NPROC) begin : g_real
      assign nv[N]                     = elig[i];
      assign ng[N*GAIN_W +: GAIN_W]    = gains[i*GAIN_W +: GAIN_W];
      assign ni[N*IDX_W +: IDX_W]      = IDX_W'(i);
    end else begin : g_pad
      assign nv[N]                     = 1'b0;
      assign ng[N*GAIN_W +: GAIN_W]    = '0;
      assign ni[N*IDX_W +: IDX_W]      = '0;
    end
  end

  for (genvar n = 0; n < NLEAF - 1; n++) begin : g_node
    localparam int L = 2 * n + 1;
    localparam int R = 2 * n + 2;
    logic take_l;
    assign take_l = left_wins(nv[L], nv[R],
                              32'(ng[L*GAIN_W +: GAIN_W]), 32'(ng[R*GAIN_W +: GAIN_W]));
    assign nv[n]                  = nv[L] | nv[R];
    assign ng[n*GAIN_W +: GAIN_W] = take_l ? ng[L*GAIN_W +: GAIN_W] : ng[R*GAIN_W +: GAIN_W];
    assign ni[n*IDX_W +: IDX_W]   = take_l ? ni[L*IDX_W +: IDX_W]   : ni[R*IDX_W +: IDX_W];
  end

  assign win_valid = nv[0];
  assign win_gain  = ng[0 +: GAIN_W];
  assign win_idx   = ni[0 +: IDX_W];

  for (genvar i = 0; i < NPROC; i++) begin : g_chk
    // R3: no eligible process beats the chosen one
    a_r3_winner_max: assert property (@(posedge clk) disable iff (!rst_n)
      elig[i] |-> (win_valid && (gains[i*GAIN_W +: GAIN_W] <= win_gain)));
    // R4: an equal-gain contender never has a lower index than the winner
    a_r4_tie_low: assert property (@(posedge clk) disable iff (!rst_n)
      (elig[i] && (gains[i*GAIN_W +: GAIN_W] == win_gain)) |-> (IDX_W'(i) >= win_idx));
  end
  // R3: the winner is itself eligible
  a_r3_winner_elig: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> elig[win_idx]);

endmodule

// File: rtl/mgp_alloc_bank.sv
module mgp_alloc_bank import mgp_pkg::*; #(
  parameter int NPROC = 8,
  parameter int CNT_W = 10,
  parameter int PW    = $clog2(NPROC + 1),
  parameter int IDX_W = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   step,
  input  logic [IDX_W-1:0]       grant_idx,
  input  logic [CNT_W-1:0]       cap_in,
  input  logic [PW-1:0]          nproc_in,
  output logic [NPROC*CNT_W-1:0] alloc_flat,
  output logic [NPROC-1:0]       elig
);
  logic [CNT_W-1:0] cap_q;
  logic [PW-1:0]    nact_q;
  logic [NPROC-1:0] bump;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q  <= '0;
      nact_q <= '0;
    end else if (clear) begin
      cap_q  <= cap_in;
      nact_q <= nproc_in;
    end
  end

  for (genvar i = 0; i < NPROC; i++) begin : g_proc
    logic [CNT_W-1:0] cnt;
    assign bump[i] = step && (grant_idx == IDX_W'(i));
    assign elig[i] = may_compete(32'(i), 32'(nact_q), 32'(cnt), 32'(cap_q));
    assign alloc_flat[i*CNT_W +: CNT_W] = cnt;

    always_ff @(posedge clk) begin
      if (!rst_n)       cnt <= '0;
      else if (clear)   cnt <= '0;
      else if (bump[i]) cnt <= cnt + 1'b1;
    end

    // R6: a count never passes the captured cap
    a_r6_under_cap: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= cap_q);
    // R8: a process outside the active range keeps a zero count
    a_r8_inactive_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(i) >= 32'(nact_q)) |-> (cnt == '0));
  end

  // R3: at most one process gains a block per step
  a_r3_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bump));

endmodule

// File: rtl/mgp_ctrl.sv
module mgp_ctrl import mgp_pkg::*; #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] total_in,
  input  logic             any_elig,
  output logic             busy,
  output logic             clear,
  output logic             step,
  output logic             done
);
  run_state_e       st;
  logic [CNT_W-1:0] left_q;

  assign busy  = (st == ST_RUN);
  assign clear = start && !busy;
  assign step  = busy && any_elig && (left_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      left_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (clear) begin
          st     <= ST_RUN;
          left_q <= total_in;
        end
        ST_RUN: if (step) begin
          left_q <= left_q - 1'b1;
        end else begin
          st   <= ST_IDLE;
          done <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5: a cycle without a step ends the run with done
  a_r5_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step) |=> (done && !busy));
  // R10: a start during a run does not reload the remaining budget
  a_r10_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && step) |=> (left_q == $past(left_q) - 1'b1));

endmodule

// File: rtl/mgain_partitioner.sv
module mgain_partitioner import mgp_pkg::*; #(
  parameter int NPROC  = 8,
  parameter int CNT_W  = 10,
  parameter int GAIN_W = 16,
  localparam int PW    = $clog2(NPROC + 1),
  localparam int IDX_W = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [PW-1:0]           nproc_active,
  input  logic [CNT_W-1:0]        total_blocks,
  input  logic [CNT_W-1:0]        cap_blocks,
  output logic [NPROC*CNT_W-1:0]  gain_addr,
  input  logic [NPROC*GAIN_W-1:0] gain_data,
  output logic [NPROC*CNT_W-1:0]  alloc_counts,
  output logic                    busy,
  output logic                    done
);
  logic             run_clear;
  logic             run_step;
  logic             any_elig;
  logic [NPROC-1:0] elig;
  logic [IDX_W-1:0] win_idx;

  mgp_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .total_in(total_blocks),
    .any_elig(any_elig), .busy(busy), .clear(run_clear), .step(run_step),
    .done(done)
  );

  mgp_alloc_bank #(.NPROC(NPROC), .CNT_W(CNT_W), .PW(PW), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .clear(run_clear), .step(run_step),
    .grant_idx(win_idx), .cap_in(cap_blocks), .nproc_in(nproc_active),
    .alloc_flat(alloc_counts), .elig(elig)
  );

  mgp_argmax #(.NPROC(NPROC), .GAIN_W(GAIN_W), .IDX_W(IDX_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .elig(elig), .gains(gain_data),
    .win_valid(any_elig), .win_idx(win_idx)
  );

  // The next gain of a process sits at the address equal to its current count.
  assign gain_addr = alloc_counts;

  // R9: counts hold while idle without a start
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(alloc_counts));
  // R2: an accepted start zeroes the counts and raises busy
  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && (alloc_counts == '0)));

endmodule

// File: tb/mgain_partitioner_tb_top.sv
module mgain_partitioner_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int CW = 5;
  localparam int GW = 8;
  localparam int PW = $clog2(NP + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [PW-1:0] nproc_active = '0;
  logic [CW-1:0] total_blocks = '0;
  logic [CW-1:0] cap_blocks = '0;
  logic [NP*CW-1:0] gain_addr;
  logic [NP*GW-1:0] gain_data;
  logic [NP*CW-1:0] alloc_counts;
  logic busy, done;
  int mode = 0;

  int total_chk = 0;
  int bad_chk = 0;
  int q_alloc[$];
  int q_cyc[$];
  string q_tag[$];
  int model_al[NP];
  int model_steps;
  int busy_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mgain_partitioner #(.NPROC(NP), .CNT_W(CW), .GAIN_W(GW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .nproc_active(nproc_active),
    .total_blocks(total_blocks), .cap_blocks(cap_blocks), .gain_addr(gain_addr),
    .gain_data(gain_data), .alloc_counts(alloc_counts), .busy(busy), .done(done)
  );

  function automatic int gval(int m, int p, int a);
    int v;
    case (m)
      0: begin v = 200 - a * 4 * (p + 1) - p * 5; if (v < 0) v = 0; end
      1: v = 50;
      default: v = (p * 37 + a * 53) % 97;
    endcase
    return v;
  endfunction

  always_comb begin
    for (int p = 0; p < NP; p++)
      gain_data[p*GW +: GW] = GW'(gval(mode, p, int'(gain_addr[p*CW +: CW])));
  end

  function automatic int cnt_of(int p);
    return int'(alloc_counts[p*CW +: CW]);
  endfunction

  task automatic check(string tag, int act, int exp);
    total_chk++;
    if (act != exp) begin
      bad_chk++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Greedy reference: strict-greater scan in index order gives the lowest index on ties.
  task automatic predict(int m, int n, int tot, int cap);
    model_steps = 0;
    for (int p = 0; p < NP; p++) model_al[p] = 0;
    for (int s = 0; s < tot; s++) begin
      int best = -1;
      int bg = 0;
      for (int p = 0; p < n; p++) begin
        if (model_al[p] < cap) begin
          int g = gval(m, p, model_al[p]);
          if (best < 0 || g > bg) begin best = p; bg = g; end
        end
      end
      if (best < 0) break;
      model_al[best]++;
      model_steps++;
    end
  endtask

  task automatic run_case(string tag, int m, int n, int tot, int cap,
                          bit extra_start, bit chk_clear);
    int held[NP];
    predict(m, n, tot, cap);
    for (int p = 0; p < NP; p++) q_alloc.push_back(model_al[p]);
    q_cyc.push_back(model_steps + 1);
    q_tag.push_back(tag);
    @(negedge clk);
    mode = m;
    nproc_active = PW'(n);
    total_blocks = CW'(tot);
    cap_blocks = CW'(cap);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (chk_clear) begin
      check({tag, " R2 busy after start"}, int'(busy), 1);
      for (int p = 0; p < NP; p++) check({tag, " R2 count cleared"}, cnt_of(p), 0);
    end
    if (extra_start) begin
      @(negedge clk);
      nproc_active = PW'(1);
      total_blocks = CW'(3);
      cap_blocks = CW'(1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (q_cyc.size() == 0);
    @(negedge clk);
    check({tag, " R9 done one cycle"}, int'(done), 0);
    for (int p = 0; p < NP; p++) held[p] = cnt_of(p);
    repeat (3) @(negedge clk);
    for (int p = 0; p < NP; p++) check({tag, " R9 counts held"}, cnt_of(p), held[p]);
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (busy) busy_cnt++;
        if (done) begin
          if (q_cyc.size() == 0) begin
            check("R9 unexpected done", 1, 0);
          end else begin
            string t = q_tag.pop_front();
            for (int p = 0; p < NP; p++)
              check({t, " R3 allocation"}, cnt_of(p), q_alloc.pop_front());
            check({t, " R5 busy cycles"}, busy_cnt, q_cyc.pop_front());
          end
          busy_cnt = 0;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total_chk++;
    bad_chk++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 done after reset", int'(done), 0);
    for (int p = 0; p < NP; p++) check("R1 count after reset", cnt_of(p), 0);

    run_case("R3 falling curves", 0, 4, 20, 31, 1'b0, 1'b0);
    run_case("R2 clear before run", 2, 4, 15, 31, 1'b0, 1'b1);
    run_case("R4 flat tie", 1, 4, 10, 4, 1'b0, 1'b0);
    run_case("R7 all capped", 1, 3, 20, 5, 1'b0, 1'b0);
    run_case("R8 two active", 2, 2, 12, 31, 1'b0, 1'b0);
    run_case("R5 zero total", 2, 4, 0, 31, 1'b0, 1'b1);
    run_case("R8 no active", 0, 0, 5, 31, 1'b0, 1'b0);
    run_case("R10 restart ignored", 0, 4, 25, 8, 1'b1, 1'b0);
    run_case("R6 tight cap", 0, 4, 31, 6, 1'b0, 1'b0);
    run_case("R3 irregular gains", 2, 4, 31, 31, 1'b0, 1'b0);

    $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end

endmodule